// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Detection

This block turns an asynchronous serial line into characters of 5 to 8 bits for a host. It runs on the system clock and moves forward only on cycles where an oversampling clock-enable is high. Three sampling ratios are available: one, sixteen or sixty-four enables per bit. In the two oversampled ratios, a falling edge on the line is checked again half a bit later. An edge that has gone high again by then is treated as noise, and the receiver goes back to hunting for a start bit.

A finished character goes into a single holding register, and a ready flag tells the host it is there. A read strobe from the host clears the flag. The block keeps three sticky error flags, cleared only by an error-clear strobe:
- a parity mismatch flag;
- a flag for a stop bit sampled low;
- a flag for a character that arrived while the previous one was still unread. The unread character is overwritten.

A separate detector watches for the line staying low for a whole frame, and shows this on a break output until the line returns high.

Top module: `async_rx_core`

## Requirements
- R1: `char_len` selects the data bits per character: code 0 = 5, 1 = 6, 2 = 7, 3 = 8. Bits arrive LSB first. `rx_data` holds the character right-aligned, with the unused upper bits zero.
- R2: `rate_sel` selects the enables per bit: code 0 = 1, code 1 = 16, codes 2 and 3 = 64. In the oversampled ratios, the start bit is confirmed half a bit (8 or 32 enables) after the falling edge. Every later bit is sampled one full bit time after the previous sample. In the 1x ratio, the first data bit is sampled on the enable after the start edge is seen.
- R3: In the 16x and 64x ratios, a start edge that is high again when confirmed produces no character and no error, and the receiver goes back to hunting. A valid frame that follows is received correctly.
- R4: With `par_en` = 1, a parity bit follows the data. `par_odd` = 1 expects odd parity over data plus parity bit, and 0 expects even parity. A mismatch sets `par_err`.
- R5: A stop bit sampled low sets `frm_err`. The receiver then waits for the line to go high before it looks for a new start bit, so a line held low yields only one character.
- R6: A finished character loads `rx_data` and sets `rx_ready`. A `rd_pulse` clears `rx_ready`. `rx_data` changes only when a character finishes.
- R7: A character that finishes while `rx_ready` is high, with no `rd_pulse` in that cycle, sets `ovr_err` and replaces `rx_data`.
- R8: When a character finishes in the same cycle as `rd_pulse`, the new character is loaded, `rx_ready` stays high and `ovr_err` is not set.
- R9: `par_err`, `frm_err` and `ovr_err` stay set until an `err_clr` pulse. An error that arrives in the same cycle as `err_clr` remains set.
- R10: `brk_det` rises once the line has been low for a whole frame time of consecutive enables: (2 + data bits + parity bit) times the ratio. It clears as soon as the line is seen high.
- R11: After reset, `rx_ready`, `rx_data`, all error flags and `brk_det` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_en | input | 1 | Oversampling clock-enable, one pulse per sample tick |
| rate_sel | input | 2 | Ticks per bit: 0 = 1x, 1 = 16x, 2/3 = 64x |
| char_len | input | 2 | Data bits: 0..3 = 5..8 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| rxd | input | 1 | Serial line, idle high |
| rd_pulse | input | 1 | Host has taken the character |
| err_clr | input | 1 | Clear all sticky error flags |
| rx_data | output | 8 | Received character, right-aligned |
| rx_ready | output | 1 | Unread character waiting |
| par_err | output | 1 | Sticky parity error |
| frm_err | output | 1 | Sticky framing error |
| ovr_err | output | 1 | Sticky overrun error |
| brk_det | output | 1 | Line held low for a frame or longer |

## Verification
The completion of a character can fall in the same cycle as a host read, and also in the same cycle as an error-clear strobe. The bench provokes both in the 1x ratio, where the stop bit is sampled on a known enable. The read and clear strobes are placed on exactly that edge, with a previous character still unread and the new character carrying a parity error. It then expects the new data loaded, ready still high, no overrun, and the parity flag still set.

// File: rtl/async_rx_pkg.sv
// Package: shared encodings and helpers for the asynchronous receiver.
// Assumes rate codes and state encodings are used only inside this block.
package async_rx_pkg;

    localparam logic [1:0] RATE_X1  = 2'd0;
    localparam logic [1:0] RATE_X16 = 2'd1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_MARK
    } rx_state_t;

    // Ticks per bit for a rate code; mid and hi are the oversampled ratios.
    function automatic int unsigned ratio_of(input logic [1:0] code,
                                             input int unsigned mid,
                                             input int unsigned hi);
        if (code == RATE_X1)
            return 1;
        else if (code == RATE_X16)
            return mid;
        else
            return hi;
    endfunction

endpackage

// File: rtl/arx_sync.sv
// Module: arx_sync
// Brings the asynchronous serial line into the clock domain through a
// chain of flops. Assumes STAGES >= 2; the chain resets to the idle level (1).
module arx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Shift the line value through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain <= '1;
        else
            chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/arx_framer.sv
// Module: arx_framer
// Finds start bits, confirms them at mid-bit, and samples data, parity and
// stop bits at the selected ratio. Emits a one-cycle done strobe with the
// assembled character and its error bits. Assumes configuration inputs are
// held stable while a frame is in flight, and that rxd is already synchronized.
module arx_framer
    import async_rx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int MID_RATIO = 16,
    parameter int HI_RATIO  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_en,
    input  logic [1:0]        rate_sel,
    input  logic [1:0]        char_len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              rxd,
    output logic              done,
    output logic [DATA_W-1:0] char_data,
    output logic              char_perr,
    output logic              char_ferr
);

    localparam int CNT_W   = $clog2(HI_RATIO + 1);
    localparam int IDX_W   = $clog2(DATA_W + 1);
    localparam int MIN_LEN = DATA_W - 3;

    rx_state_t         state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              pbit;

    logic [CNT_W-1:0]  full_cnt;
    logic [CNT_W-1:0]  half_cnt;
    logic [IDX_W-1:0]  nbits;
    logic              at_full;
    logic              is_x1;

    // Derive bit period, half period and character length from configuration.
    always_comb begin
        full_cnt = CNT_W'(ratio_of(rate_sel, MID_RATIO, HI_RATIO));
        half_cnt = CNT_W'(ratio_of(rate_sel, MID_RATIO, HI_RATIO) / 2);
        nbits    = IDX_W'(MIN_LEN) + IDX_W'(char_len);
        at_full  = (cnt == full_cnt);
        is_x1    = (rate_sel == RATE_X1);
    end

    // Frame state machine: hunt, confirm, sample bits, check stop, await mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            pbit    <= 1'b0;
        end else if (samp_en) begin
            case (state)
                ST_IDLE: begin
                    if (!rxd) begin
                        cnt     <= CNT_W'(1);
                        bit_idx <= '0;
                        shreg   <= '0;
                        pbit    <= 1'b0;
                        state   <= is_x1 ? ST_DATA : ST_START;
                    end
                end
                ST_START: begin
                    if (cnt == half_cnt) begin
                        cnt   <= CNT_W'(1);
                        state <= rxd ? ST_IDLE : ST_DATA;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_DATA: begin
                    if (at_full) begin
                        shreg   <= {rxd, shreg[DATA_W-1:1]};
                        cnt     <= CNT_W'(1);
                        bit_idx <= bit_idx + IDX_W'(1);
                        if (bit_idx == nbits - IDX_W'(1))
                            state <= par_en ? ST_PAR : ST_STOP;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_PAR: begin
                    if (at_full) begin
                        pbit  <= rxd;
                        cnt   <= CNT_W'(1);
                        state <= ST_STOP;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_STOP: begin
                    if (at_full) begin
                        cnt   <= CNT_W'(1);
                        state <= rxd ? ST_IDLE : ST_MARK;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_MARK: begin
                    if (rxd)
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Right-align the character and evaluate parity and stop-bit errors.
    always_comb begin
        done      = samp_en && (state == ST_STOP) && at_full;
        char_data = shreg >> (IDX_W'(DATA_W) - nbits);
        char_perr = par_en & ((^char_data) ^ pbit ^ par_odd);
        char_ferr = ~rxd;
    end

endmodule

// File: rtl/arx_status.sv
// Module: arx_status
// Holds the received character for the host, the ready flag and the sticky
// error flags. Assumes done is a single-cycle strobe. A load wins over a
// read in the same cycle, and a new error wins over a clear.
module arx_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] char_data,
    input  logic              char_perr,
    input  logic              char_ferr,
    input  logic              rd_pulse,
    input  logic              err_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              par_err,
    output logic              frm_err,
    output logic              ovr_err
);

    // Load the holding register and track whether it has been read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_ready <= 1'b0;
        end else if (done) begin
            rx_data  <= char_data;
            rx_ready <= 1'b1;
        end else if (rd_pulse) begin
            rx_ready <= 1'b0;
        end
    end

    // Accumulate sticky error flags until the host clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_err <= 1'b0;
            frm_err <= 1'b0;
            ovr_err <= 1'b0;
        end else begin
            par_err <= (par_err & ~err_clr) | (done & char_perr);
            frm_err <= (frm_err & ~err_clr) | (done & char_ferr);
            ovr_err <= (ovr_err & ~err_clr) | (done & rx_ready & ~rd_pulse);
        end
    end

endmodule

// File: rtl/arx_break.sv
// Module: arx_break
// Counts consecutive low sample ticks on the synchronized line and flags a
// break once a whole frame time has passed. Assumes rxd is synchronized;
// the flag and count drop on the first cycle the line is high.
module arx_break
    import async_rx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int MID_RATIO = 16,
    parameter int HI_RATIO  = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       samp_en,
    input  logic [1:0] rate_sel,
    input  logic [1:0] char_len,
    input  logic       par_en,
    input  logic       rxd,
    output logic       brk_det
);

    localparam int BRK_W   = $clog2(HI_RATIO * (DATA_W + 3) + 1);
    localparam int MIN_LEN = DATA_W - 3;

    logic [BRK_W-1:0] low_cnt;
    logic [BRK_W-1:0] frame_ticks;

    // Frame time in ticks: start + data + parity + stop, times the ratio.
    always_comb begin
        frame_ticks = (BRK_W'(2 + MIN_LEN) + BRK_W'(char_len) + BRK_W'(par_en))
                    * BRK_W'(ratio_of(rate_sel, MID_RATIO, HI_RATIO));
    end

    // Count low ticks and raise the break flag at the frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
            brk_det <= 1'b0;
        end else if (rxd) begin
            low_cnt <= '0;
            brk_det <= 1'b0;
        end else if (samp_en && !brk_det) begin
            low_cnt <= low_cnt + BRK_W'(1);
            if (low_cnt == frame_ticks - BRK_W'(1))
                brk_det <= 1'b1;
        end
    end

endmodule

// File: rtl/async_rx_core.sv
// Module: async_rx_core
// Top of the asynchronous receiver: synchronizer, framer, host holding
// register with sticky errors, and break detector. Assumes samp_en pulses
// at the selected multiple of the baud rate and configuration is static
// while characters are in flight.
module async_rx_core #(
    parameter int DATA_W      = 8,
    parameter int MID_RATIO   = 16,
    parameter int HI_RATIO    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_en,
    input  logic [1:0]        rate_sel,
    input  logic [1:0]        char_len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              rxd,
    input  logic              rd_pulse,
    input  logic              err_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              par_err,
    output logic              frm_err,
    output logic              ovr_err,
    output logic              brk_det
);

    logic              rxd_s;
    logic              char_done;
    logic [DATA_W-1:0] char_data;
    logic              char_perr;
    logic              char_ferr;

    arx_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rxd),
        .q     (rxd_s)
    );

    arx_framer #(
        .DATA_W    (DATA_W),
        .MID_RATIO (MID_RATIO),
        .HI_RATIO  (HI_RATIO)
    ) i_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .samp_en   (samp_en),
        .rate_sel  (rate_sel),
        .char_len  (char_len),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .rxd       (rxd_s),
        .done      (char_done),
        .char_data (char_data),
        .char_perr (char_perr),
        .char_ferr (char_ferr)
    );

    arx_status #(.DATA_W(DATA_W)) i_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (char_done),
        .char_data (char_data),
        .char_perr (char_perr),
        .char_ferr (char_ferr),
        .rd_pulse  (rd_pulse),
        .err_clr   (err_clr),
        .rx_data   (rx_data),
        .rx_ready  (rx_ready),
        .par_err   (par_err),
        .frm_err   (frm_err),
        .ovr_err   (ovr_err)
    );

    arx_break #(
        .DATA_W    (DATA_W),
        .MID_RATIO (MID_RATIO),
        .HI_RATIO  (HI_RATIO)
    ) i_break (
        .clk      (clk),
        .rst_n    (rst_n),
        .samp_en  (samp_en),
        .rate_sel (rate_sel),
        .char_len (char_len),
        .par_en   (par_en),
        .rxd      (rxd_s),
        .brk_det  (brk_det)
    );

endmodule

// File: rtl/arx_checker.sv
// Module: arx_checker
// Temporal checks on the receiver's host-side outputs, bound into the top.
// Assumes it observes the internal synchronized line and completion strobe.
module arx_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_pulse,
    input logic              err_clr,
    input logic              char_done,
    input logic              rxd_s,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_ready,
    input logic              par_err,
    input logic              frm_err,
    input logic              ovr_err,
    input logic              brk_det
);

    // R6
    ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_ready) |-> $past(rd_pulse));

    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !char_done |=> $stable(rx_data));

    // R8
    ready_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        char_done |=> rx_ready);

    // R7
    ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_err) |-> ($past(rx_ready) && !$past(rd_pulse)));

    // R9
    perr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(par_err) |-> $past(err_clr));

    // R9
    ferr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frm_err) |-> $past(err_clr));

    // R9
    ovr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovr_err) |-> $past(err_clr));

    // R10
    brk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(brk_det) |-> $past(rxd_s));

endmodule

bind async_rx_core arx_checker #(.DATA_W(DATA_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_pulse  (rd_pulse),
    .err_clr   (err_clr),
    .char_done (char_done),
    .rxd_s     (rxd_s),
    .rx_data   (rx_data),
    .rx_ready  (rx_ready),
    .par_err   (par_err),
    .frm_err   (frm_err),
    .ovr_err   (ovr_err),
    .brk_det   (brk_det)
);

// File: tb/test_async_rx_core.sv
`timescale 1ns/1ps
// Bench for async_rx_core: a vector table of frames walked by one loop,
// then directed tests for reset, false starts, overrun, sticky flags,
// read/completion coincidence and break.
module test_async_rx_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] div = 2'd0;
    logic       samp_en;
    logic [1:0] rate_sel = 2'd1;
    logic [1:0] char_len = 2'd3;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rxd = 1'b1;
    logic       rd_pulse = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready;
    logic       par_err;
    logic       frm_err;
    logic       ovr_err;
    logic       brk_det;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #2 clk = ~clk;

    // Sample enable once every four clocks.
    always @(posedge clk) div <= div + 2'd1;
    assign samp_en = (div == 2'd3);

    async_rx_core i_async_rx_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .samp_en  (samp_en),
        .rate_sel (rate_sel),
        .char_len (char_len),
        .par_en   (par_en),
        .par_odd  (par_odd),
        .rxd      (rxd),
        .rd_pulse (rd_pulse),
        .err_clr  (err_clr),
        .rx_data  (rx_data),
        .rx_ready (rx_ready),
        .par_err  (par_err),
        .frm_err  (frm_err),
        .ovr_err  (ovr_err),
        .brk_det  (brk_det)
    );

    // {rate, len, par_en, par_odd, bad_par, bad_stop, data}
    localparam logic [15:0] VECS [8] = '{
        {2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},
        {2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'hF3},
        {2'd2, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h2D},
        {2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 8'h55},
        {2'd1, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 8'hC3},
        {2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'h7E},
        {2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h81},
        {2'd3, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 8'hFF}
    };

    function automatic int ratio(input logic [1:0] r);
        if (r == 2'd0) return 1;
        if (r == 2'd1) return 16;
        return 64;
    endfunction

    function automatic logic [7:0] mask_of(input logic [1:0] len);
        return 8'hFF >> (3 - len);
    endfunction

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge clk);
            while (!samp_en) @(negedge clk);
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_read();
        @(negedge clk); rd_pulse = 1'b1;
        @(negedge clk); rd_pulse = 1'b0;
    endtask

    task automatic host_clr();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    // Drive one frame; optional read+clear strobe on the stop-sample edge (1x).
    task automatic send_frame(input logic [7:0] d, input logic bad_par,
                              input logic bad_stop, input logic coin);
        int r;
        int n;
        logic [7:0] m;
        r = ratio(rate_sel);
        n = 5 + int'(char_len);
        m = d & mask_of(char_len);
        tick(1);
        rxd = 1'b0;
        tick(r);
        for (int i = 0; i < n; i++) begin
            rxd = m[i];
            tick(r);
        end
        if (par_en) begin
            rxd = (^m) ^ par_odd ^ bad_par;
            tick(r);
        end
        rxd = ~bad_stop;
        tick(r);
        rxd = 1'b1;
        if (coin) begin
            rd_pulse = 1'b1;
            err_clr  = 1'b1;
            @(negedge clk);
            rd_pulse = 1'b0;
            err_clr  = 1'b0;
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (6) @(negedge clk);
        // R11 reset state
        chk("R11 rx_ready", 32'(rx_ready), 32'd0);
        chk("R11 rx_data", 32'(rx_data), 32'd0);
        chk("R11 flags", 32'({par_err, frm_err, ovr_err}), 32'd0);
        chk("R11 brk_det", 32'(brk_det), 32'd0);
        rst_n = 1'b1;
        tick(4);

        // Table of frames: R1 lengths, R2 ratios, R4 parity, R5 framing, R6 ready.
        for (int v = 0; v < 8; v++) begin
            logic [15:0] e;
            e = VECS[v];
            rate_sel = e[15:14];
            char_len = e[13:12];
            par_en   = e[11];
            par_odd  = e[10];
            send_frame(e[7:0], e[9], e[8], 1'b0);
            tick(4);
            chk($sformatf("R6 vec%0d ready", v), 32'(rx_ready), 32'd1);
            chk($sformatf("R1 R2 vec%0d data", v), 32'(rx_data), 32'(e[7:0] & mask_of(e[13:12])));
            chk($sformatf("R4 vec%0d par_err", v), 32'(par_err), 32'(e[11] & e[9]));
            chk($sformatf("R5 vec%0d frm_err", v), 32'(frm_err), 32'(e[8]));
            host_read();
            host_clr();
            tick(1);
            chk($sformatf("R6 vec%0d ready after read", v), 32'(rx_ready), 32'd0);
        end

        // R3 false start at 16x, then a valid frame
        rate_sel = 2'd1; char_len = 2'd3; par_en = 1'b0;
        tick(1); rxd = 1'b0; tick(3); rxd = 1'b1; tick(40);
        chk("R3 glitch 16x no char", 32'(rx_ready), 32'd0);
        chk("R3 glitch 16x no error", 32'({par_err, frm_err}), 32'd0);
        send_frame(8'h3C, 1'b0, 1'b0, 1'b0);
        tick(4);
        chk("R3 recovery data", 32'(rx_data), 32'h3C);
        host_read();

        // R3 false start at 64x
        rate_sel = 2'd2;
        tick(1); rxd = 1'b0; tick(20); rxd = 1'b1; tick(100);
        chk("R3 glitch 64x no char", 32'(rx_ready), 32'd0);

        // R7 overrun: two frames, no read
        rate_sel = 2'd1;
        send_frame(8'h11, 1'b0, 1'b0, 1'b0);
        send_frame(8'h22, 1'b0, 1'b0, 1'b0);
        tick(4);
        chk("R7 ovr_err set", 32'(ovr_err), 32'd1);
        chk("R7 data replaced", 32'(rx_data), 32'h22);
        host_clr();
        tick(1);
        chk("R9 ovr cleared by err_clr", 32'(ovr_err), 32'd0);
        host_read();

        // R9 sticky parity error survives a read and a clean frame
        par_en = 1'b1; par_odd = 1'b0;
        send_frame(8'h5A, 1'b1, 1'b0, 1'b0);
        tick(4);
        host_read();
        send_frame(8'h6B, 1'b0, 1'b0, 1'b0);
        tick(4);
        chk("R9 par_err sticky", 32'(par_err), 32'd1);
        chk("R9 later data", 32'(rx_data), 32'h6B);
        host_clr();
        tick(1);
        chk("R9 par_err cleared", 32'(par_err), 32'd0);
        host_read();

        // R8 completion with read and clear on the same edge (1x)
        rate_sel = 2'd0;
        send_frame(8'h3A, 1'b0, 1'b0, 1'b0);
        tick(2);
        send_frame(8'hC5, 1'b1, 1'b0, 1'b1);
        tick(3);
        chk("R8 no overrun", 32'(ovr_err), 32'd0);
        chk("R8 ready kept", 32'(rx_ready), 32'd1);
        chk("R8 new data", 32'(rx_data), 32'hC5);
        chk("R9 error beats clear", 32'(par_err), 32'd1);
        host_read();
        host_clr();

        // R10 break at 16x, 8 bits, no parity: 160 ticks
        rate_sel = 2'd1; par_en = 1'b0;
        tick(1); rxd = 1'b0;
        tick(150);
        chk("R10 no break before frame time", 32'(brk_det), 32'd0);
        tick(20);
        chk("R10 break asserted", 32'(brk_det), 32'd1);
        chk("R5 break char framing", 32'(frm_err), 32'd1);
        chk("R5 break char data", 32'(rx_data), 32'h00);
        host_read();
        tick(200);
        chk("R5 single char while low", 32'(rx_ready), 32'd0);
        rxd = 1'b1;
        tick(1);
        chk("R10 break clears on high", 32'(brk_det), 32'd0);
        host_clr();
        tick(4);

        finish_run();
    end

endmodule